// File: doc/BRIEF.md
# Comparator Edge Flag and Request Controller

This block collects edge events from the filtered outputs of four comparator channels. Each channel sends a one-cycle pulse when its output rises and another when it falls. The block turns each pulse into a sticky flag. Software clears a flag by writing one to its bit.

From its flags, each channel drives two level outputs: an interrupt request and a DMA request. Each output has its own pair of enable bits, so the rising flag and the falling flag can be routed to either output or to both.

Software reaches the flags and the enables through a 32-bit register port: byte address, write strobe, write data and combinational read data. Each channel owns a 0x20-byte window. Inside a window, the status register sits at offset 0x10, the interrupt-enable register at 0x14 and the DMA-enable register at 0x18.

Top module: `cmp_edge_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every flag and every enable is zero, both request outputs are low on every channel, and every address reads zero.
- R2: A pulse on a channel's rising-edge input sets bit 0 of that channel's status register (offset 0x10) at the next clock edge. The bit stays set until it is cleared.
- R3: A pulse on a channel's falling-edge input sets bit 1 of that channel's status register at the next clock edge. The bit stays set until it is cleared.
- R4: Writing a 1 to status bit 0 or bit 1 clears that flag. Writing a 0 to a bit leaves that flag unchanged.
- R5: If an edge pulse and a write-one clear of the same flag arrive in the same cycle, the flag ends up set.
- R6: The interrupt-enable register (offset 0x14) holds two writable bits. Bit 0 enables the rising flag and bit 1 enables the falling flag. The channel's interrupt request is high exactly when some flag is set and its enable bit is set.
- R7: The DMA-enable register (offset 0x18) holds two writable bits with the same bit meanings as the interrupt-enable register. The channel's DMA request is formed from the flags and these enables in the same way.
- R8: Channel n occupies byte addresses n*0x20 to n*0x20+0x1F. A write reaches only the addressed channel.
- R9: Any offset other than 0x10, 0x14 or 0x18, and any data bit above bit 1, reads as zero. Writes to those offsets or bits change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rise_pulse | input | 4 | One-cycle rising-edge events, one bit per channel |
| fall_pulse | input | 4 | One-cycle falling-edge events, one bit per channel |
| bus_addr | input | 7 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | output | 4 | Interrupt request per channel |
| dma_req | output | 4 | DMA request per channel |

## Verification
A wrong flag or enable shows up on the request outputs in the same cycle it exists, whenever the matching enable is set. It also shows up on a read of the status or enable register, with no delay, because the read path is combinational. The bench therefore compares both request vectors and the read data on every cycle against a model. A lost set, a wrongly kept flag, or a write that leaks to a neighbour channel or a reserved offset is reported within one cycle of the edge that caused it. Random traffic mixes pulses with clears and enable writes. Directed cases cover the cycle where a pulse and a clear collide, and writes to reserved space.

// File: rtl/cmp_edge_pkg.sv
// Package: constants and types shared by the comparator edge controller.
// Assumes byte addressing with 32-bit registers and a power-of-two channel stride.
package cmp_edge_pkg;
    localparam int DEF_NUM_CH   = 4;
    localparam int DEF_STRIDE   = 32;
    localparam int DATA_W       = 32;
    localparam int FLAG_W       = 2;

    // Bit positions inside status and enable registers.
    localparam int BIT_RISE     = 0;
    localparam int BIT_FALL     = 1;

    // Register offsets inside one channel window.
    localparam int OFF_STATUS   = 'h10;
    localparam int OFF_IRQ_EN   = 'h14;
    localparam int OFF_DMA_EN   = 'h18;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_STATUS = 2'd1,
        REG_IRQ_EN = 2'd2,
        REG_DMA_EN = 2'd3
    } reg_kind_e;

    // Zero-extend a flag pair onto the data bus.
    function automatic logic [DATA_W-1:0] widen(input logic [FLAG_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[FLAG_W-1:0] = v;
        return r;
    endfunction
endpackage

// File: rtl/cmp_edge_decode.sv
// Module: cmp_edge_decode
// Splits a byte address into a channel index and a register kind.
// Assumes the address is exactly channel bits above offset bits; every
// offset other than the three defined word addresses decodes to REG_NONE.
module cmp_edge_decode
    import cmp_edge_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int STRIDE = DEF_STRIDE,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int OFF_W = $clog2(STRIDE),
    localparam int ADDR_W = CH_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch_idx,
    output reg_kind_e         kind
);
    logic [OFF_W-1:0] off;

    // Split the address into channel and offset fields.
    always_comb begin
        ch_idx = addr[ADDR_W-1:OFF_W];
        off    = addr[OFF_W-1:0];
    end

    // Map the offset to a register kind; anything else is reserved.
    always_comb begin
        if (off == OFF_W'(OFF_STATUS))      kind = REG_STATUS;
        else if (off == OFF_W'(OFF_IRQ_EN)) kind = REG_IRQ_EN;
        else if (off == OFF_W'(OFF_DMA_EN)) kind = REG_DMA_EN;
        else                                kind = REG_NONE;
    end

    AST_DECODE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != REG_NONE) |-> (addr[1:0] == 2'b00)); // R9
endmodule

// File: rtl/cmp_edge_chan.sv
// Module: cmp_edge_chan
// One channel: sticky rise/fall flags, write-one-to-clear, two enable
// registers and the derived interrupt and DMA request levels.
// Assumes write strobes are already qualified by address decode and that
// edge pulses are synchronous to clk.
module cmp_edge_chan
    import cmp_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              we_stat,
    input  logic              we_ien,
    input  logic              we_den,
    input  logic [FLAG_W-1:0] wbits,
    output logic [FLAG_W-1:0] stat_o,
    output logic [FLAG_W-1:0] ien_o,
    output logic [FLAG_W-1:0] den_o,
    output logic              irq_o,
    output logic              dreq_o
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] ien_q;
    logic [FLAG_W-1:0] den_q;
    logic [FLAG_W-1:0] set_v;
    logic [FLAG_W-1:0] clr_v;

    // Gather the per-bit set and clear requests.
    always_comb begin
        set_v           = '0;
        set_v[BIT_RISE] = rise_i;
        set_v[BIT_FALL] = fall_i;
        clr_v           = we_stat ? wbits : '0;
    end

    // Sticky flags: set has priority over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_v) | set_v;
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (we_ien) ien_q <= wbits;
    end

    // DMA-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      den_q <= '0;
        else if (we_den) den_q <= wbits;
    end

    // Request levels and register views.
    always_comb begin
        stat_o = flags_q;
        ien_o  = ien_q;
        den_o  = den_q;
        irq_o  = |(flags_q & ien_q);
        dreq_o = |(flags_q & den_q);
    end

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> stat_o[BIT_RISE]); // R2
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> stat_o[BIT_FALL]); // R3
    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_stat && wbits[BIT_RISE] && !rise_i) |=> !stat_o[BIT_RISE]); // R4
    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[BIT_RISE] && !(we_stat && wbits[BIT_RISE])) |=> stat_o[BIT_RISE]); // R4
    AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_ien |=> $stable(ien_o)); // R6
    AST_DEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_den |=> (den_o == $past(wbits))); // R7
endmodule

// File: rtl/cmp_edge_ctrl.sv
// Module: cmp_edge_ctrl (top)
// Edge flag and request controller for NUM_CH comparator channels laid
// out at STRIDE-byte windows. Writes take effect at the clock edge; reads
// are combinational. Assumes single-cycle register accesses, no wait states.
module cmp_edge_ctrl
    import cmp_edge_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int STRIDE = DEF_STRIDE,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + $clog2(STRIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rise_pulse,
    input  logic [NUM_CH-1:0] fall_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_req,
    output logic [NUM_CH-1:0] dma_req
);
    logic [CH_W-1:0]   ch_idx;
    reg_kind_e         kind;
    logic [NUM_CH-1:0] ch_hit;
    logic [FLAG_W-1:0] stat_a [NUM_CH];
    logic [FLAG_W-1:0] ien_a  [NUM_CH];
    logic [FLAG_W-1:0] den_a  [NUM_CH];

    cmp_edge_decode #(.NUM_CH(NUM_CH), .STRIDE(STRIDE)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .ch_idx (ch_idx),
        .kind   (kind)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Per-channel hit for a write strobe.
        always_comb ch_hit[g] = bus_we && (ch_idx == CH_W'(g));

        cmp_edge_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise_pulse[g]),
            .fall_i  (fall_pulse[g]),
            .we_stat (ch_hit[g] && (kind == REG_STATUS)),
            .we_ien  (ch_hit[g] && (kind == REG_IRQ_EN)),
            .we_den  (ch_hit[g] && (kind == REG_DMA_EN)),
            .wbits   (bus_wdata[FLAG_W-1:0]),
            .stat_o  (stat_a[g]),
            .ien_o   (ien_a[g]),
            .den_o   (den_a[g]),
            .irq_o   (irq_req[g]),
            .dreq_o  (dma_req[g])
        );
    end

    // Read mux: select the addressed channel's register, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_W'(i)) begin
                case (kind)
                    REG_STATUS: bus_rdata = widen(stat_a[i]);
                    REG_IRQ_EN: bus_rdata = widen(ien_a[i]);
                    REG_DMA_EN: bus_rdata = widen(den_a[i]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    AST_WRITE_ONE_CH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_hit)); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:FLAG_W] == '0); // R9
endmodule

// File: tb/cmp_edge_ctrl_tb.sv
`timescale 1ns/1ps
module cmp_edge_ctrl_tb;
    localparam int NCH = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  rise_pulse = '0;
    logic [3:0]  fall_pulse = '0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_req;
    logic [3:0]  dma_req;

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0] m_flag [NCH];
    logic [1:0] m_ien  [NCH];
    logic [1:0] m_den  [NCH];

    cmp_edge_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .dma_req(dma_req)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] exp_read(input logic [6:0] a);
        int c;
        c = int'(a[6:5]);
        case (a[4:0])
            5'h10:   return {30'd0, m_flag[c]};
            5'h14:   return {30'd0, m_ien[c]};
            5'h18:   return {30'd0, m_den[c]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int c = 0; c < NCH; c++) r[c] = |(m_flag[c] & m_ien[c]);
        return r;
    endfunction

    function automatic logic [3:0] exp_dma();
        logic [3:0] r;
        for (int c = 0; c < NCH; c++) r[c] = |(m_flag[c] & m_den[c]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle: inputs set at negedge, outputs compared, model advanced at posedge.
    task automatic step(input logic [3:0] r, input logic [3:0] f, input logic [6:0] a,
                        input logic we, input logic [31:0] wd, input string req);
        int c;
        rise_pulse = r; fall_pulse = f; bus_addr = a; bus_we = we; bus_wdata = wd;
        #1;
        check({req, " rdata"}, bus_rdata, exp_read(a));
        check("R6 irq", {28'd0, irq_req}, {28'd0, exp_irq()});
        check("R7 dma", {28'd0, dma_req}, {28'd0, exp_dma()});
        @(posedge clk);
        c = int'(a[6:5]);
        for (int k = 0; k < NCH; k++) begin
            logic [1:0] clr;
            clr = (we && k == c && a[4:0] == 5'h10) ? wd[1:0] : 2'b00;
            m_flag[k] = (m_flag[k] & ~clr) | {f[k], r[k]};
        end
        if (we && a[4:0] == 5'h14) m_ien[c] = wd[1:0];
        if (we && a[4:0] == 5'h18) m_den[c] = wd[1:0];
        @(negedge clk);
    endtask

    function automatic logic [6:0] pick_addr();
        logic [6:0] a;
        int s;
        s = int'($urandom_range(0, 9));
        a[6:5] = 2'($urandom_range(0, 3));
        case (s)
            0, 1, 2: a[4:0] = 5'h10;
            3, 4:    a[4:0] = 5'h14;
            5, 6:    a[4:0] = 5'h18;
            default: a[4:0] = 5'($urandom_range(0, 31));
        endcase
        return a;
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < NCH; c++) begin m_flag[c] = 0; m_ien[c] = 0; m_den[c] = 0; end
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state across every address
        for (int a = 0; a < 128; a += 4) step(4'h0, 4'h0, 7'(a), 1'b0, 32'h0, "R1 reset");

        // R2/R3: directed sets on channel 2, then read back
        step(4'b0100, 4'b0000, 7'h50, 1'b0, 0, "R2 set rise");
        step(4'b0000, 4'b0100, 7'h50, 1'b0, 0, "R2 read");
        step(4'b0000, 4'b0000, 7'h50, 1'b0, 0, "R3 read fall");
        // R6: enable rise into irq, falling into dma on channel 2
        step(0, 0, 7'h54, 1'b1, 32'hFFFF_FFFD, "R6 ien write");
        step(0, 0, 7'h58, 1'b1, 32'h2, "R7 den write");
        step(0, 0, 7'h54, 1'b0, 0, "R9 upper bits dropped");
        // R4: write 0 leaves, write 1 clears rise only
        step(0, 0, 7'h50, 1'b1, 32'h0, "R4 write zero");
        step(0, 0, 7'h50, 1'b1, 32'h1, "R4 clear rise");
        step(0, 0, 7'h50, 1'b0, 0, "R4 read");
        // R5: set and clear same cycle on falling flag
        step(0, 4'b0100, 7'h50, 1'b1, 32'h2, "R5 collide");
        step(0, 0, 7'h50, 1'b0, 0, "R5 set wins");
        // R8/R9: writes to reserved offsets and other channels
        step(0, 0, 7'h40, 1'b1, 32'hFFFF_FFFF, "R9 reserved wr");
        step(0, 0, 7'h5C, 1'b1, 32'hFFFF_FFFF, "R9 reserved wr");
        step(0, 0, 7'h12, 1'b1, 32'hFFFF_FFFF, "R9 misaligned wr");
        step(0, 0, 7'h14, 1'b1, 32'h3, "R8 other ch");
        for (int a = 0; a < 128; a += 4) step(0, 0, 7'(a), 1'b0, 0, "R8 R9 map");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r, f;
            r = 4'($urandom) & 4'($urandom);
            f = 4'($urandom) & 4'($urandom);
            step(r, f, pick_addr(), 1'($urandom_range(0, 1)), $urandom, "R2 R3 R4 random");
        end
        for (int a = 0; a < 128; a += 4) step(0, 0, 7'(a), 1'b0, 0, "R8 final map");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule